// File: doc/BRIEF.md
# OSD Field Sequencer and Highlight Timer

This block paces a small on-screen display at field rate. It finds the leading edge of the vertical flyback input and counts the fields it marks. From that count it selects one of three icon screens. In automatic mode the screen advances through 0, 1 and 2 and then wraps. The step period is a programmed multiple of eight fields. An override value pins the screen to one fixed member of the set.

The same field count drives the display control code. A host writes a three-bit code that turns the display off, turns it on with plain colours, or turns it on with one of four buttons (up, down, plus, minus) highlighted. A highlight lasts a fixed number of fields. After that the stored code falls back by itself to plain-on, and the read-back port shows the value it fell back to. Writes arrive one per cycle on a small bus. A select bit picks either the sequence register or the control register.

Top module: `osd_field_seq`

## Requirements
- R1: After reset the screen index is 0, the mode is automatic with period field 0, the control code reads 000, the display enable is low and no highlight line is set.
- R2: A field is counted once per rising edge of `vsync_i`. A high level that lasts many cycles counts as one field.
- R3: In automatic mode (mode field 00) the screen index goes 0→1→2→0, and it advances once every 8×P counted fields. P is the period field, bits 3:0 of a sequence-register write (`wr_sel_i`=1).
- R4: A period field of 0 acts as P=1, so the screen steps every 8 fields.
- R5: The mode field sits at bits 5:4 of a sequence-register write. Values 01, 10 and 11 pin the screen to 0, 1 and 2, and in those modes fields are not counted.
- R6: A sequence write that changes the mode or the period clears the field count. Moving from a fixed mode to automatic restarts the screen at 0. A write that repeats the current values leaves the count and the screen alone.
- R7: A control-register write (`wr_sel_i`=0) stores bits 2:0 as the code. `osd_en_o` is high whenever the code is not 000. The unassigned codes 101 and 110 are stored as 001.
- R8: The highlight codes are 010 (up), 100 (down), 011 (plus) and 111 (minus). Each sets one line of `hl_sel_o`: bit 0, bit 1, bit 2 and bit 3 respectively. Codes 000 and 001 set none.
- R9: A highlight code stays for exactly 32 counted fields after its write. It then becomes 001, and `ctrl_rb_o` reads 001.
- R10: Writing any code restarts the 32-field window. Writing 000 turns the display off at once, and no fallback follows.
- R11: When a write and a field edge fall in the same cycle, the write wins. A sequence write that changes the configuration drops that field, and a control write does not count that field toward the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical flyback level, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = control register, 1 = sequence register |
| wr_data_i | input | PER_W+2 | Write data: period in the low bits, mode above it; the control code uses bits 2:0 |
| screen_o | output | 2 | Current icon screen index |
| osd_en_o | output | 1 | Display enable |
| hl_sel_o | output | 4 | One-hot highlight select: up, down, plus, minus |
| ctrl_rb_o | output | 3 | Read-back of the current control code |

## Verification
A register write and a field edge can land in the same cycle. Both then affect the field count and the highlight window. The bench provokes this by raising `vsync_i` in the cycle that carries the write. It does so with a changed sequence configuration, with an unchanged one, and with a fresh highlight code. A reference model applies write-wins ordering, and its expected screen and fallback cycle are compared with the outputs on every clock. An unchanged sequence write must leave that field counted, so a design that drops every colliding field is exposed.

// File: rtl/osd_seq_pkg.sv
package osd_seq_pkg;

    localparam int NUM_SCREENS = 3;
    localparam int SCR_W       = 2;
    localparam int MODE_W      = 2;
    localparam int CODE_W      = 3;
    localparam int HL_N        = 4;

    localparam logic [CODE_W-1:0] CODE_OFF   = 3'b000;
    localparam logic [CODE_W-1:0] CODE_ON    = 3'b001;
    localparam logic [CODE_W-1:0] CODE_UP    = 3'b010;
    localparam logic [CODE_W-1:0] CODE_PLUS  = 3'b011;
    localparam logic [CODE_W-1:0] CODE_DOWN  = 3'b100;
    localparam logic [CODE_W-1:0] CODE_MINUS = 3'b111;

    // Code that lights highlight line idx
    function automatic logic [CODE_W-1:0] hl_code(input int idx);
        case (idx)
            0:       return CODE_UP;
            1:       return CODE_DOWN;
            2:       return CODE_PLUS;
            default: return CODE_MINUS;
        endcase
    endfunction

    function automatic logic is_hl(input logic [CODE_W-1:0] c);
        return (c == CODE_UP) || (c == CODE_DOWN) ||
               (c == CODE_PLUS) || (c == CODE_MINUS);
    endfunction

    // Unassigned codes fold to plain-on
    function automatic logic [CODE_W-1:0] norm_code(input logic [CODE_W-1:0] c);
        return ((c == 3'b101) || (c == 3'b110)) ? CODE_ON : c;
    endfunction

endpackage

// File: rtl/osd_vedge.sv
module osd_vedge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vsync_i,
    output logic tick_o
);
    typedef struct packed {
        logic vs;
    } edge_s;

    edge_s q, d;

    always_comb begin
        d    = q;
        d.vs = vsync_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tick_o = vsync_i & ~q.vs;
endmodule

// File: rtl/osd_screen_rot.sv
module osd_screen_rot
    import osd_seq_pkg::*;
#(
    parameter int UNIT_FIELDS = 8,
    parameter int PER_W       = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              cfg_we_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [PER_W-1:0]  per_i,
    output logic [SCR_W-1:0]  screen_o
);
    localparam int UW = $clog2(UNIT_FIELDS);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [PER_W-1:0]  per;
        logic [UW-1:0]     fcnt;
        logic [PER_W-1:0]  pcnt;
        logic [SCR_W-1:0]  scr;
    } rot_s;

    rot_s q, d;
    logic [PER_W-1:0] per_eff;
    logic             changed;

    always_comb begin
        d       = q;
        per_eff = (q.per == '0) ? PER_W'(1) : q.per;
        changed = cfg_we_i && ((mode_i != q.mode) || (per_i != q.per));
        if (changed) begin
            d.mode = mode_i;
            d.per  = per_i;
            d.fcnt = '0;
            d.pcnt = '0;
            if ((mode_i == '0) && (q.mode != '0)) d.scr = '0;
        end else if (tick_i && (q.mode == '0)) begin
            if (q.fcnt == UW'(UNIT_FIELDS - 1)) begin
                d.fcnt = '0;
                if (q.pcnt == per_eff - PER_W'(1)) begin
                    d.pcnt = '0;
                    d.scr  = (q.scr == SCR_W'(NUM_SCREENS - 1)) ? '0 : q.scr + SCR_W'(1);
                end else begin
                    d.pcnt = q.pcnt + PER_W'(1);
                end
            end else begin
                d.fcnt = q.fcnt + UW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign screen_o = (q.mode == '0) ? q.scr : SCR_W'(q.mode - MODE_W'(1));
endmodule

// File: rtl/osd_hl_timer.sv
module osd_hl_timer
    import osd_seq_pkg::*;
#(
    parameter int HOLD_FIELDS = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              we_i,
    input  logic [CODE_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o,
    output logic              osd_en_o,
    output logic [HL_N-1:0]   hl_sel_o
);
    localparam int TW = $clog2(HOLD_FIELDS);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [TW-1:0]     tcnt;
    } hl_s;

    hl_s q, d;

    always_comb begin
        d = q;
        if (we_i) begin
            d.code = norm_code(data_i);
            d.tcnt = '0;
        end else if (tick_i && is_hl(q.code)) begin
            if (q.tcnt == TW'(HOLD_FIELDS - 1)) begin
                d.code = CODE_ON;
                d.tcnt = '0;
            end else begin
                d.tcnt = q.tcnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign code_o   = q.code;
    assign osd_en_o = (q.code != CODE_OFF);

    for (genvar g = 0; g < HL_N; g++) begin : g_hl
        assign hl_sel_o[g] = (q.code == hl_code(g));
    end
endmodule

// File: rtl/osd_field_seq.sv
module osd_field_seq
    import osd_seq_pkg::*;
#(
    parameter int UNIT_FIELDS = 8,
    parameter int PER_W       = 4,
    parameter int HOLD_FIELDS = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    vsync_i,
    input  logic                    wr_en_i,
    input  logic                    wr_sel_i,
    input  logic [PER_W+MODE_W-1:0] wr_data_i,
    output logic [SCR_W-1:0]        screen_o,
    output logic                    osd_en_o,
    output logic [HL_N-1:0]         hl_sel_o,
    output logic [CODE_W-1:0]       ctrl_rb_o
);
    logic field_tick;

    osd_vedge u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .vsync_i (vsync_i),
        .tick_o  (field_tick)
    );

    osd_screen_rot #(
        .UNIT_FIELDS (UNIT_FIELDS),
        .PER_W       (PER_W)
    ) u_rot (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (field_tick),
        .cfg_we_i (wr_en_i & wr_sel_i),
        .mode_i   (wr_data_i[PER_W+MODE_W-1:PER_W]),
        .per_i    (wr_data_i[PER_W-1:0]),
        .screen_o (screen_o)
    );

    osd_hl_timer #(
        .HOLD_FIELDS (HOLD_FIELDS)
    ) u_hl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (field_tick),
        .we_i     (wr_en_i & ~wr_sel_i),
        .data_i   (wr_data_i[CODE_W-1:0]),
        .code_o   (ctrl_rb_o),
        .osd_en_o (osd_en_o),
        .hl_sel_o (hl_sel_o)
    );
endmodule

// File: rtl/osd_field_seq_chk.sv
module osd_field_seq_chk #(
    parameter int HOLD_FIELDS = 32
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       field_tick,
    input logic       wr_en_i,
    input logic       wr_sel_i,
    input logic [1:0] screen_o,
    input logic       osd_en_o,
    input logic [3:0] hl_sel_o,
    input logic [2:0] ctrl_rb_o
);
    localparam int CW = $clog2(HOLD_FIELDS) + 1;

    logic          ctrl_wr, seq_wr;
    logic [CW-1:0] hl_fields;

    assign ctrl_wr = wr_en_i & ~wr_sel_i;
    assign seq_wr  = wr_en_i & wr_sel_i;

    // Fields seen since the last control write while a highlight is shown
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       hl_fields <= '0;
        else if (ctrl_wr)                  hl_fields <= '0;
        else if (field_tick && |hl_sel_o)  hl_fields <= hl_fields + CW'(1);
    end

    a_r8_hl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hl_sel_o));

    a_r7_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_rb_o == 3'b000) |-> (!osd_en_o && hl_sel_o == 4'b0000));

    a_r3_screen_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        screen_o != 2'd3);

    a_r3_hold_between_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!field_tick && !seq_wr) |=> $stable(screen_o));

    a_r3_step_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seq_wr |=> ($stable(screen_o) ||
                     screen_o == (($past(screen_o) == 2'd2) ? 2'd0 : $past(screen_o) + 2'd1)));

    a_r9_code_only_falls_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_wr |=> ($stable(ctrl_rb_o) || ctrl_rb_o == 3'b001));

    a_r9_window_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|hl_sel_o) |-> (hl_fields < CW'(HOLD_FIELDS)));

    a_r9_fallback_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ctrl_wr && field_tick && (|hl_sel_o) && hl_fields == CW'(HOLD_FIELDS - 1))
        |=> ctrl_rb_o == 3'b001);
endmodule

bind osd_field_seq osd_field_seq_chk #(.HOLD_FIELDS(HOLD_FIELDS)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .field_tick (field_tick),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .screen_o   (screen_o),
    .osd_en_o   (osd_en_o),
    .hl_sel_o   (hl_sel_o),
    .ctrl_rb_o  (ctrl_rb_o)
);

// File: tb/osd_field_seq_tb_top.sv
`timescale 1ns/1ps
module osd_field_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vs = 1'b0;
    logic       we = 1'b0;
    logic       sel = 1'b0;
    logic [5:0] wd = '0;
    logic [1:0] screen;
    logic       osd_en;
    logic [3:0] hl_sel;
    logic [2:0] rb;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference state
    int m_mode, m_alt, m_fields, m_scr, m_code, m_hold, m_pvs;

    always #10 clk = ~clk;

    osd_field_seq dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .vsync_i   (vs),
        .wr_en_i   (we),
        .wr_sel_i  (sel),
        .wr_data_i (wd),
        .screen_o  (screen),
        .osd_en_o  (osd_en),
        .hl_sel_o  (hl_sel),
        .ctrl_rb_o (rb)
    );

    function automatic int exp_hl(int c);
        case (c)
            2: return 1;
            4: return 2;
            3: return 4;
            7: return 8;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 0; m_alt = 0; m_fields = 0; m_scr = 0;
        m_code = 0; m_hold = 0; m_pvs = 0;
    endtask

    task automatic model_step();
        bit tick;
        int nm, na, c;
        tick  = (vs == 1'b1) && (m_pvs == 0);
        m_pvs = vs;
        if (we && sel) begin
            nm = int'(wd[5:4]);
            na = int'(wd[3:0]);
            if (nm != m_mode || na != m_alt) begin
                if (nm == 0 && m_mode != 0) m_scr = 0;
                m_mode = nm; m_alt = na; m_fields = 0;
            end else if (tick && m_mode == 0) begin
                m_fields++;
                if (m_fields == ((m_alt == 0) ? 1 : m_alt) * 8) begin
                    m_fields = 0; m_scr = (m_scr + 1) % 3;
                end
            end
        end else if (tick && m_mode == 0) begin
            m_fields++;
            if (m_fields == ((m_alt == 0) ? 1 : m_alt) * 8) begin
                m_fields = 0; m_scr = (m_scr + 1) % 3;
            end
        end
        if (we && !sel) begin
            c = int'(wd[2:0]);
            if (c == 5 || c == 6) c = 1;
            m_code = c; m_hold = 0;
        end else if (tick && exp_hl(m_code) != 0) begin
            m_hold++;
            if (m_hold == 32) begin m_code = 1; m_hold = 0; end
        end
    endtask

    task automatic compare();
        int es;
        es = (m_mode == 0) ? m_scr : m_mode - 1;
        n_cmp += 4;
        if (int'(screen) != es) begin
            n_bad++; $display("FAIL %s screen_o got %0d exp %0d", cur_req, screen, es);
        end
        if (osd_en != (m_code != 0)) begin
            n_bad++; $display("FAIL %s osd_en_o got %0d exp %0d", cur_req, osd_en, m_code != 0);
        end
        if (int'(hl_sel) != exp_hl(m_code)) begin
            n_bad++; $display("FAIL %s hl_sel_o got %0h exp %0h", cur_req, hl_sel, exp_hl(m_code));
        end
        if (int'(rb) != m_code) begin
            n_bad++; $display("FAIL %s ctrl_rb_o got %0d exp %0d", cur_req, rb, m_code);
        end
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit v, input bit w, input bit s, input logic [5:0] d);
        vs = v; we = w; sel = s; wd = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        vs = 1'b0; we = 1'b0;
        compare();
    endtask

    task automatic fields(input int n, input int hi = 1);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < hi; k++) cyc(1, 0, 0, '0);
            for (int k = 0; k < 3; k++)  cyc(0, 0, 0, '0);
        end
    endtask

    task automatic wr_seq(input int mode, input int per);
        cyc(0, 1, 1, 6'((mode << 4) | per));
    endtask

    task automatic wr_ctl(input int code);
        cyc(0, 1, 0, 6'(code));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state straight after reset
        cur_req = "R1";
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, '0);
        // R4: period field 0 steps every 8 fields
        cur_req = "R4";
        fields(30);
        // R2: long high levels count once each
        cur_req = "R2";
        fields(10, 12);
        // R3: periods 2 and 15
        cur_req = "R3";
        wr_seq(0, 2);
        fields(50);
        wr_seq(0, 15);
        fields(365);
        // R5: fixed screens, no counting
        cur_req = "R5";
        wr_seq(1, 15); fields(5);
        wr_seq(2, 15); fields(5);
        wr_seq(3, 3);  fields(30);
        // R6: entry to auto restarts, same-value rewrite keeps count, change clears it
        cur_req = "R6";
        wr_seq(0, 1); fields(13);
        wr_seq(0, 1); fields(5);
        fields(5);
        wr_seq(0, 2); fields(12);
        wr_seq(0, 1); fields(20);
        // R7: control codes and folding of unassigned values
        cur_req = "R7";
        wr_ctl(0); fields(1);
        wr_ctl(1); fields(1);
        wr_ctl(5); fields(40);
        wr_ctl(6); fields(2);
        wr_ctl(0); fields(2);
        // R8: each highlight line
        cur_req = "R8";
        wr_ctl(2); fields(2);
        wr_ctl(4); fields(2);
        wr_ctl(3); fields(2);
        wr_ctl(7); fields(2);
        // R9: fallback after exactly 32 fields
        cur_req = "R9";
        wr_ctl(2); fields(40);
        // R10: restart of window and immediate off
        cur_req = "R10";
        wr_ctl(3); fields(20);
        wr_ctl(7); fields(31);
        fields(3);
        wr_ctl(4); fields(10);
        wr_ctl(0); fields(40);
        // R11: write in the same cycle as a field edge
        cur_req = "R11";
        wr_seq(0, 1); fields(6);
        cyc(1, 1, 1, 6'h02); fields(20);
        cyc(1, 1, 1, 6'h02); fields(20);
        cyc(0, 0, 0, '0);
        wr_ctl(2); fields(10);
        cyc(1, 1, 0, 6'h02);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, '0);
        fields(35);
        cyc(1, 1, 1, 6'h10); fields(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule